// File: doc/BRIEF.md
# Skewed-Associative Read Cache

This block is a small four-way read cache in which every way computes its own set index from the request address. Two address fields just above the byte offset, called the low field and the high field, feed the index logic. Way 0 takes the low field XOR the high field. Way k rotates the low field left by k bits before the XOR. The index path therefore holds only XOR gates and fixed wiring. Two addresses that land in the same set of one way usually land in different sets of the other ways, so a few colliding lines can live side by side without raising the associativity.

A client presents an address with a read strobe. One cycle later the block reports either a hit with the stored word or a miss. After a miss, a refill port delivers the line, which is a single word. The block writes that line into one of the four ways. It first tries the way that already holds the address. Next it tries the lowest-numbered way whose hashed slot is empty. If all four slots are full, a two-bit round-robin pointer picks the way. Each tag entry keeps every address bit above the offset, so a match is exact even though the index is hashed.

Top module: `skc_cache`

## Requirements
- R1: While rst_ni is low and after it is released, rsp_valid_o, hit_o and miss_o are 0 and no line is valid, so the first lookup of any address misses.
- R2: A request sampled at a clock edge with req_valid_i high produces rsp_valid_o high on the next cycle, with exactly one of hit_o and miss_o high. With no request, all three outputs are 0 on the next cycle. On a miss or with no request, rdata_o is 0.
- R3: Way k (k = 0..3) indexes its 16-entry store with rotl(addr[5:2], k) XOR addr[9:6], where rotl is a left rotation within 4 bits. Five addresses that share the way-0 index but have different low fields can all be resident at once.
- R4: A hit requires the stored tag, addr[15:2], to equal the request exactly. The offset bits [1:0] have no effect, and an address that differs only in bit 15 misses.
- R5: On a hit, rdata_o is the word most recently refilled for that address.
- R6: A refill of an address not present is written to the lowest-numbered way whose hashed slot for that address is empty.
- R7: When all four hashed slots are full, the refill replaces way rr. rr starts at 0 after reset and steps by one, wrapping from 3 to 0, only on refills that use it.
- R8: A refill of an address already present overwrites the way that holds it. No address is held in two ways, so at most one way hits.
- R9: A lookup in the same cycle as a refill sees the contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Read strobe |
| req_addr_i | input | 16 | Read address |
| rsp_valid_o | output | 1 | Response present, one cycle after the request |
| hit_o | output | 1 | Response is a hit |
| miss_o | output | 1 | Response is a miss |
| rdata_o | output | 32 | Word read on a hit, else 0 |
| refill_valid_i | input | 1 | Refill strobe |
| refill_addr_i | input | 16 | Address of the refill line |
| refill_data_i | input | 32 | Data of the refill line |

## Verification
The hardest state to reach is one where all four hashed slots of an address are full, because the skew normally spreads lines apart. The stimulus reaches it with addresses whose low field is zero. All their rotations are then equal, so each such address maps to the same index in every way. A run of six such fills then shows which way is taken when a slot is empty and the round-robin order once none is, through which addresses still hit. To show the skew itself, five addresses that collide in way 0 are filled and must all stay resident. A randomised phase over a small address pool follows, checked cycle by cycle against a behavioural model.

// File: rtl/skc_pkg.sv
package skc_pkg;
  typedef enum logic [1:0] {
    VIC_MATCH,
    VIC_FREE,
    VIC_RR
  } vic_reason_e;
endpackage

// File: rtl/skc_hash.sv
module skc_hash #(
  parameter int IDX_W = 4,
  parameter int SHIFT = 0
) (
  input  logic [IDX_W-1:0] lo_i,
  input  logic [IDX_W-1:0] hi_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int S = SHIFT % IDX_W;

  logic [IDX_W-1:0] rot;

  generate
    if (S == 0) begin : g_plain
      assign rot = lo_i;
    end else begin : g_rot
      assign rot = {lo_i[IDX_W-1-S:0], lo_i[IDX_W-1:IDX_W-S]};
    end
  endgenerate

  assign idx_o = rot ^ hi_i;
endmodule

// File: rtl/skc_bank.sv
module skc_bank #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 14,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_data_o,
  input  logic [IDX_W-1:0]  rf_idx_i,
  input  logic [TAG_W-1:0]  rf_tag_i,
  output logic              rf_slot_valid_o,
  output logic              rf_slot_match_o,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[rf_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[rf_idx_i]  <= rf_tag_i;
      data_q[rf_idx_i] <= wr_data_i;
    end
  end

  assign lk_hit_o        = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  assign lk_data_o       = data_q[lk_idx_i];
  assign rf_slot_valid_o = valid_q[rf_idx_i];
  assign rf_slot_match_o = valid_q[rf_idx_i] && (tag_q[rf_idx_i] == rf_tag_i);

  // R8: a written slot holds the refilled tag on the next cycle
  a_r8_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(rf_idx_i)] && tag_q[$past(rf_idx_i)] == $past(rf_tag_i));
endmodule

// File: rtl/skc_victim.sv
module skc_victim
  import skc_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 refill_i,
  input  logic [NUM_BANKS-1:0] slot_valid_i,
  input  logic [NUM_BANKS-1:0] slot_match_i,
  output logic [NUM_BANKS-1:0] grant_o
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [BANK_W-1:0] rr_q;
  logic [BANK_W-1:0] match_sel, free_sel, sel;
  vic_reason_e       reason;

  always_comb begin
    match_sel = '0;
    free_sel  = '0;
    for (int k = NUM_BANKS - 1; k >= 0; k--) begin
      if (slot_match_i[k]) match_sel = BANK_W'(k);
      if (!slot_valid_i[k]) free_sel = BANK_W'(k);
    end
    if (|slot_match_i) begin
      reason = VIC_MATCH;
      sel    = match_sel;
    end else if (!(&slot_valid_i)) begin
      reason = VIC_FREE;
      sel    = free_sel;
    end else begin
      reason = VIC_RR;
      sel    = rr_q;
    end
    grant_o      = '0;
    grant_o[sel] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (refill_i && reason == VIC_RR)
      rr_q <= (rr_q == BANK_W'(NUM_BANKS - 1)) ? '0 : rr_q + 1'b1;
  end

  a_r6_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_i |-> $onehot(grant_o));
  a_r6_free_slot_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_i && !(|slot_match_i) && !(&slot_valid_i)) |-> !(|(grant_o & slot_valid_i)));
  a_r7_rr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(refill_i && (&slot_valid_i) && !(|slot_match_i)) |=> $stable(rr_q));
endmodule

// File: rtl/skc_cache.sv
module skc_cache #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int OFF_W     = 2,
  parameter int IDX_W     = 4,
  parameter int NUM_BANKS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              refill_valid_i,
  input  logic [ADDR_W-1:0] refill_addr_i,
  input  logic [DATA_W-1:0] refill_data_i
);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int LO_LSB = OFF_W;
  localparam int HI_LSB = OFF_W + IDX_W;

  logic [TAG_W-1:0]     lk_tag, rf_tag;
  logic [NUM_BANKS-1:0] bank_hit, slot_valid, slot_match, grant;
  logic [DATA_W-1:0]    bank_data [NUM_BANKS];
  logic [DATA_W-1:0]    hit_data;
  logic                 unused_off;

  assign lk_tag     = req_addr_i[ADDR_W-1:OFF_W];
  assign rf_tag     = refill_addr_i[ADDR_W-1:OFF_W];
  assign unused_off = ^{req_addr_i[OFF_W-1:0], refill_addr_i[OFF_W-1:0]};

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [IDX_W-1:0] lk_idx, rf_idx;

      skc_hash #(.IDX_W(IDX_W), .SHIFT(b)) u_lk_hash (
        .lo_i (req_addr_i[LO_LSB +: IDX_W]),
        .hi_i (req_addr_i[HI_LSB +: IDX_W]),
        .idx_o(lk_idx)
      );

      skc_hash #(.IDX_W(IDX_W), .SHIFT(b)) u_rf_hash (
        .lo_i (refill_addr_i[LO_LSB +: IDX_W]),
        .hi_i (refill_addr_i[HI_LSB +: IDX_W]),
        .idx_o(rf_idx)
      );

      skc_bank #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_bank (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .lk_idx_i       (lk_idx),
        .lk_tag_i       (lk_tag),
        .lk_hit_o       (bank_hit[b]),
        .lk_data_o      (bank_data[b]),
        .rf_idx_i       (rf_idx),
        .rf_tag_i       (rf_tag),
        .rf_slot_valid_o(slot_valid[b]),
        .rf_slot_match_o(slot_match[b]),
        .wr_en_i        (refill_valid_i && grant[b]),
        .wr_data_i      (refill_data_i)
      );
    end
  endgenerate

  skc_victim #(.NUM_BANKS(NUM_BANKS)) u_victim (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .refill_i    (refill_valid_i),
    .slot_valid_i(slot_valid),
    .slot_match_i(slot_match),
    .grant_o     (grant)
  );

  always_comb begin
    hit_data = '0;
    for (int k = 0; k < NUM_BANKS; k++)
      hit_data = hit_data | (bank_data[k] & {DATA_W{bank_hit[k]}});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      miss_o      <= 1'b0;
      rdata_o     <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      hit_o       <= req_valid_i && (|bank_hit);
      miss_o      <= req_valid_i && !(|bank_hit);
      rdata_o     <= (req_valid_i && (|bank_hit)) ? hit_data : '0;
    end
  end

  // R8: never two ways holding the probed address
  a_r8_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_hit));
  a_r8_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_valid_i |-> $onehot0(slot_match));
  a_r2_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (hit_o ^ miss_o));
  a_r2_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !hit_o && !miss_o && rdata_o == '0);
endmodule

// File: tb/skc_cache_tb.sv
`timescale 1ns/1ps
module skc_cache_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        rsp_valid, hit, miss;
  logic [31:0] rdata;
  logic        refill_valid = 1'b0;
  logic [15:0] refill_addr = '0;
  logic [31:0] refill_data = '0;

  always #2 clk = ~clk;

  skc_cache u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .hit_o(hit), .miss_o(miss), .rdata_o(rdata),
    .refill_valid_i(refill_valid), .refill_addr_i(refill_addr),
    .refill_data_i(refill_data)
  );

  int checks = 0;
  int fails = 0;

  // behavioural reference
  bit          mv [4][16];
  logic [13:0] mt [4][16];
  logic [31:0] md [4][16];
  int          rr;
  logic        ev, eh;
  logic [31:0] ed;
  int          hb, wb;

  function automatic int hidx(int k, logic [15:0] a);
    int lo, hi, rot;
    lo  = int'(a[5:2]);
    hi  = int'(a[9:6]);
    rot = ((lo << k) | (lo >> (4 - k))) & 15;
    return rot ^ hi;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (mv[k, i]) mv[k][i] = 1'b0;
      rr = 0; ev = 1'b0; eh = 1'b0; ed = '0;
    end else begin
      hb = -1;
      if (req_valid)
        for (int k = 0; k < 4; k++)
          if (mv[k][hidx(k, req_addr)] && mt[k][hidx(k, req_addr)] == req_addr[15:2]) hb = k;
      ev = req_valid;
      eh = req_valid && hb >= 0;
      ed = eh ? md[hb][hidx(hb, req_addr)] : '0;
      if (refill_valid) begin
        wb = -1;
        for (int k = 0; k < 4; k++)
          if (wb < 0 && mv[k][hidx(k, refill_addr)] &&
              mt[k][hidx(k, refill_addr)] == refill_addr[15:2]) wb = k;
        if (wb < 0)
          for (int k = 0; k < 4; k++)
            if (wb < 0 && !mv[k][hidx(k, refill_addr)]) wb = k;
        if (wb < 0) begin
          wb = rr;
          rr = (rr + 1) % 4;
        end
        mv[wb][hidx(wb, refill_addr)] = 1'b1;
        mt[wb][hidx(wb, refill_addr)] = refill_addr[15:2];
        md[wb][hidx(wb, refill_addr)] = refill_data;
      end
    end
  end

  // cycle-by-cycle comparison (R2, R5)
  always @(negedge clk) begin
    if (rst_ni) begin
      checks++;
      if (rsp_valid !== ev || hit !== eh || miss !== (ev && !eh) || rdata !== ed) begin
        fails++;
        $display("FAIL R2/R5 per-cycle: actual v%0b h%0b m%0b d%08h expected v%0b h%0b m%0b d%08h",
                 rsp_valid, hit, miss, rdata, ev, eh, ev && !eh, ed);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [15:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic refill(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    refill_valid = 1'b1; refill_addr = a; refill_data = d;
    @(negedge clk);
    refill_valid = 1'b0;
  endtask

  task automatic expect_hit(input string tag, input logic [15:0] a, input logic [31:0] d);
    lookup(a);
    chk(tag, {31'b0, hit}, 32'd1);
    chk(tag, rdata, d);
  endtask

  task automatic expect_miss(input string tag, input logic [15:0] a);
    lookup(a);
    chk(tag, {31'b0, miss}, 32'd1);
    chk(tag, rdata, 32'd0);
  endtask

  function automatic logic [15:0] mk(int tg, int hi, int lo, int off);
    return 16'((tg << 10) | (hi << 6) | (lo << 2) | off);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 reset hit/miss", {30'b0, hit, miss}, 32'd0);
    rst_ni = 1'b1;
    expect_miss("R1 cold miss", 16'h1234);

    // R3: five lines sharing the way-0 index all stay resident
    for (int x = 1; x <= 5; x++) refill(mk(0, x, x, 0), 32'hA000_0000 + x);
    for (int x = 1; x <= 5; x++) expect_hit("R3 skewed spread", mk(0, x, x, 0), 32'hA000_0000 + x);

    // R6/R7: low field 0 maps to index 9 in every way
    for (int t = 1; t <= 4; t++) refill(mk(t, 9, 0, 0), 32'hB000_0000 + t);
    for (int t = 1; t <= 4; t++) expect_hit("R6 free slot fill", mk(t, 9, 0, 0), 32'hB000_0000 + t);
    refill(mk(5, 9, 0, 0), 32'hB000_0005);
    expect_miss("R7 rr evicts way 0", mk(1, 9, 0, 0));
    expect_hit("R7 way 1 kept", mk(2, 9, 0, 0), 32'hB000_0002);
    expect_hit("R7 new line", mk(5, 9, 0, 0), 32'hB000_0005);
    refill(mk(6, 9, 0, 0), 32'hB000_0006);
    expect_miss("R7 rr evicts way 1", mk(2, 9, 0, 0));
    expect_hit("R7 way 2 kept", mk(3, 9, 0, 0), 32'hB000_0003);
    expect_hit("R7 second new line", mk(6, 9, 0, 0), 32'hB000_0006);

    // R4: offset ignored, exact tag
    expect_hit("R4 offset ignored", mk(3, 9, 0, 3), 32'hB000_0003);
    expect_miss("R4 bit15 differs", mk(3, 9, 0, 0) ^ 16'h8000);

    // R8: refill of a resident line overwrites in place
    refill(mk(5, 9, 0, 0), 32'hC0DE_0005);
    expect_hit("R8 overwrite data", mk(5, 9, 0, 0), 32'hC0DE_0005);
    expect_hit("R8 neighbour kept", mk(3, 9, 0, 0), 32'hB000_0003);

    // R9: lookup alongside refill sees old contents
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk(1, 9, 0, 0);
    refill_valid = 1'b1; refill_addr = mk(1, 9, 0, 0); refill_data = 32'hD00D_0001;
    @(negedge clk);
    req_valid = 1'b0; refill_valid = 1'b0;
    chk("R9 same-cycle miss", {31'b0, miss}, 32'd1);
    expect_hit("R9 then hit", mk(1, 9, 0, 0), 32'hD00D_0001);

    // randomised traffic on a small pool, compared every cycle
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      a = mk($urandom_range(3), $urandom_range(3), $urandom_range(3), $urandom_range(3));
      if (n % 7 == 0) begin
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        refill_valid = 1'b1; refill_addr = a; refill_data = $urandom;
        @(negedge clk);
        req_valid = 1'b0; refill_valid = 1'b0;
      end else begin
        lookup(a);
        if (miss) refill(a, $urandom);
      end
    end
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule